// File: doc/BRIEF.md
# Access Wait-State Cycle Calculator

This block tells a bus master how many bus cycles one memory access costs. The caller presents an address, an access width and a flag that marks the access as sequential or non-sequential. The block then returns the cost as a combinational count. The address space is split into sixteen pages of 16 MiB each, and the cost depends on which page the address falls in.

Internal memories have fixed costs. The three external ROM windows and the save-memory window get their costs from a 16-bit wait-control register. When that register is written, the block recomputes the costs for those four windows and holds the results in registers.

A caller that wants the block to hold it can raise a request instead of only reading the count. The block then drives a stall output high for exactly that many cycles.

Top module: `ws_cost_calc`

## Requirements
- R1: The page is address bits [27:24], and bits [31:28] and [23:0] have no effect on the cost. Pages 0x0, 0x1, 0x3 and 0x4 cost 1 cycle for every width and for both sequential and non-sequential accesses.
- R2: Page 0x2 costs 6 cycles for a word access and 3 cycles for a byte or halfword access, whether sequential or not.
- R3: Pages 0x5, 0x6 and 0x7 cost 2 cycles for a word access and 1 cycle for a byte or halfword access, whether sequential or not.
- R4: ROM windows 0, 1 and 2 occupy pages 0x8–0x9, 0xA–0xB and 0xC–0xD. Both pages of a window have the same costs. A non-sequential byte or halfword access costs 1 plus {4,3,2,8}, indexed by that window's 2-bit first-access field.
- R5: A sequential byte or halfword ROM access costs 1 plus a value picked by that window's 1-bit second-access field. The value is 2 or 1 for window 0, 4 or 1 for window 1 and 8 or 1 for window 2 (field value 0 or 1).
- R6: A non-sequential word ROM access costs the halfword non-sequential cost plus the halfword sequential cost. A sequential word ROM access costs twice the halfword sequential cost.
- R7: Pages 0xE and 0xF cost 1 plus {4,3,2,8}, indexed by the save field, for every width and for both sequential and non-sequential accesses.
- R8: The field positions in the wait-control register are: save [1:0], window 0 first [3:2], window 0 second [4], window 1 first [6:5], window 1 second [7], window 2 first [9:8], window 2 second [10]. After reset every field is zero.
- R9: A register write changes no cost in the cycle in which it is presented. The new costs apply from the cycle after the clock edge that captures the write.
- R10: Width code 0 is byte, 1 is halfword, and 2 or 3 is word. When the stall output is low, a request is accepted and the stall output then stays high for exactly the cost of the accepted access. Requests raised while the stall output is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write strobe for the wait-control register |
| cfg_wdata | input | 16 | Value written to the wait-control register |
| req_valid | input | 1 | Asks for a stall of the current access's cost |
| req_addr | input | 32 | Access address |
| req_width | input | 2 | Access width code |
| req_seq | input | 1 | 1 = sequential access |
| cost | output | 5 | Cycle cost of the presented access |
| stall | output | 1 | High while an accepted access is being paid for |

## Verification
The hardest case to reach is the boundary around a register write. In that cycle the cost must still come from the old settings, and in the very next cycle it must come from the new ones. The bench therefore writes the register while a ROM address is held steady, and it checks the cost both before and after the capturing edge. A second hard case is a request raised while a stall is running. The bench sends such a request with an address whose cost is higher, then checks that the stall length still matches the first access only.

// File: rtl/ws_cost_calc.sv
module ws_cost_calc #(
  parameter int CW   = 5,
  parameter int CTLW = 16,
  parameter int AW   = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [CTLW-1:0] cfg_wdata,
  input  logic            req_valid,
  input  logic [AW-1:0]   req_addr,
  input  logic [1:0]      req_width,
  input  logic            req_seq,
  output logic [CW-1:0]   cost,
  output logic            stall
);
  localparam int NWIN = 3;
  localparam logic [CW-1:0] MAX_COST = CW'(18);

  function automatic logic [CW-1:0] first_cost(input logic [1:0] f);
    case (f)
      2'd0: first_cost = CW'(5);
      2'd1: first_cost = CW'(4);
      2'd2: first_cost = CW'(3);
      default: first_cost = CW'(9);
    endcase
  endfunction

  function automatic logic [CW-1:0] second_cost(input int w, input logic f);
    if (f) second_cost = CW'(2);
    else second_cost = CW'((2 << w) + 1);
  endfunction

  function automatic logic [1:0] first_field(input logic [CTLW-1:0] r, input int w);
    first_field = r[2 + 3*w +: 2];
  endfunction

  function automatic logic second_field(input logic [CTLW-1:0] r, input int w);
    second_field = r[4 + 3*w];
  endfunction

  logic [CW-1:0] n16 [NWIN];
  logic [CW-1:0] s16 [NWIN];
  logic [CW-1:0] sav;
  logic [CW-1:0] cnt;

  genvar g;
  generate
    for (g = 0; g < NWIN; g++) begin : g_win
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          n16[g] <= first_cost(2'd0);
          s16[g] <= second_cost(g, 1'b0);
        end else if (cfg_we) begin
          n16[g] <= first_cost(first_field(cfg_wdata, g));
          s16[g] <= second_cost(g, second_field(cfg_wdata, g));
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) sav <= first_cost(2'd0);
    else if (cfg_we) sav <= first_cost(cfg_wdata[1:0]);
  end

  wire [3:0] page = req_addr[27:24];
  wire       wide = req_width[1];
  wire [1:0] win  = 2'((page - 4'd8) >> 1);

  always_comb begin
    cost = CW'(1);
    case (page)
      4'h2: cost = wide ? CW'(6) : CW'(3);
      4'h5, 4'h6, 4'h7: cost = wide ? CW'(2) : CW'(1);
      4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD: begin
        if (wide) cost = req_seq ? CW'(s16[win] << 1) : n16[win] + s16[win];
        else cost = req_seq ? s16[win] : n16[win];
      end
      4'hE, 4'hF: cost = sav;
      default: cost = CW'(1);
    endcase
  end

  wire accept = req_valid && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (accept) cnt <= cost;
    else if (cnt != '0) cnt <= cnt - CW'(1);
  end

  assign stall = (cnt != '0);

  // R10
  stall_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> cnt == $past(cost));
  // R10
  stall_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0) |=> cnt == $past(cnt) - CW'(1));
  // R4
  cost_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cost >= CW'(1) && cost <= MAX_COST);
  // R6
  rom_seq_word_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (page >= 4'h8 && page <= 4'hD && wide && req_seq) |-> cost[0] == 1'b0);
  // R9
  table_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(sav) && $stable(n16[0]) && $stable(s16[2]));
endmodule

// File: tb/ws_cost_calc_test.sv
module ws_cost_calc_test;
  logic clk = 0;
  logic rst_n = 0;
  logic cfg_we = 0;
  logic [15:0] cfg_wdata = 0;
  logic req_valid = 0;
  logic [31:0] req_addr = 0;
  logic [1:0] req_width = 0;
  logic req_seq = 0;
  logic [4:0] cost;
  logic stall;
  int nchk = 0, nbad = 0;
  logic [15:0] ctl_model = 0;

  always #2 clk = ~clk;

  ws_cost_calc uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_width(req_width), .req_seq(req_seq),
    .cost(cost), .stall(stall));

  function automatic int nwait(input int f);
    int t[4] = '{4, 3, 2, 8};
    return t[f];
  endfunction

  function automatic int ref_cost(input logic [31:0] a, input logic [1:0] w,
                                  input logic s, input logic [15:0] r);
    int p = a[27:24];
    bit wd = (w >= 2);
    int n, q, k;
    if (p == 2) return wd ? 6 : 3;
    if (p >= 5 && p <= 7) return wd ? 2 : 1;
    if (p >= 14) return 1 + nwait(r[1:0]);
    if (p >= 8 && p <= 13) begin
      k = (p - 8) / 2;
      n = 1 + nwait(int'(r[2+3*k +: 2]));
      q = 1 + (r[4+3*k] ? 1 : (2 << k));
      if (wd) return s ? 2*q : n + q;
      return s ? q : n;
    end
    return 1;
  endfunction

  task automatic check(input string tag, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nbad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic probe(input string tag, input logic [31:0] a, input logic [1:0] w, input logic s);
    @(negedge clk);
    req_addr = a; req_width = w; req_seq = s;
    #1 check(tag, cost, ref_cost(a, w, s, ctl_model));
  endtask

  task automatic wr(input logic [15:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0; ctl_model = v;
  endtask

  initial begin
    #400000;
    nbad++; nchk++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end

  initial begin
    int exp_c, len;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R10 reset stall", stall, 0);
    // R8 reset state: ROM window 0 non-seq half = 5, seq = 3
    probe("R8", 32'h0800_0000, 2'd1, 0);
    probe("R8", 32'h0D00_0010, 2'd2, 1);
    probe("R8", 32'hE000_0000, 2'd0, 0);
    // R1 default pages, high bits ignored
    probe("R1", 32'h0000_0000, 2'd2, 0);
    probe("R1", 32'hF400_1234, 2'd2, 1);
    probe("R1", 32'h1300_0000, 2'd0, 0);
    // R2 / R3
    probe("R2", 32'h0200_0000, 2'd2, 1);
    probe("R2", 32'h02FF_FFFF, 2'd1, 0);
    probe("R3", 32'h0600_0000, 2'd3, 0);
    probe("R3", 32'h0700_0000, 2'd0, 1);
    // R4 R5 R6 R7 at extreme settings
    wr(16'h0000 | (2'd3 << 2) | (2'd3 << 5) | (2'd3 << 8) | 2'd3);
    probe("R4", 32'h0900_0000, 2'd1, 0);
    probe("R6", 32'h0C00_0000, 2'd2, 0);
    probe("R6", 32'h0D00_0000, 2'd2, 1);
    probe("R7", 32'h0F00_0000, 2'd2, 1);
    wr(16'h0490 | (2'd2 << 5));
    probe("R5", 32'h0800_0000, 2'd1, 1);
    probe("R5", 32'h0B00_0000, 2'd0, 1);
    probe("R5", 32'h0C00_0000, 2'd1, 1);
    // R9 write boundary
    @(negedge clk);
    req_addr = 32'h0A00_0000; req_width = 2'd1; req_seq = 0;
    cfg_we = 1; cfg_wdata = 16'h0020;
    #1 check("R9 before edge", cost, ref_cost(req_addr, 2'd1, 0, ctl_model));
    @(negedge clk);
    cfg_we = 0; ctl_model = 16'h0020;
    #1 check("R9 after edge", cost, 4);
    // R10 stall length, request during stall ignored
    wr(16'h0000);
    @(negedge clk);
    req_addr = 32'h0800_0000; req_width = 2'd2; req_seq = 0; req_valid = 1;
    exp_c = ref_cost(req_addr, 2'd2, 0, ctl_model);
    @(negedge clk);
    req_addr = 32'h0C00_0000; req_seq = 0;
    len = 0;
    #1 if (stall) len++;
    @(negedge clk);
    req_valid = 0;
    #1 while (stall) begin len++; @(negedge clk); #1; end
    check("R10 stall length", len, exp_c);
    // random
    for (int i = 0; i < 3000; i++) begin
      if ($urandom_range(0, 15) == 0) wr(16'($urandom));
      probe("R1-random", $urandom, 2'($urandom), 1'($urandom));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  end
endmodule